// File: doc/BRIEF.md
# Dead-Time and Live-Time Gate

This block tracks when a pulse-height converter cannot accept a new input and turns that into a single dead-time level. An input that crosses the lower discriminator starts dead time. If the converter then takes the event (its busy flag rises while no anti-coincidence inhibit is present), dead time holds until the converter is reset. The reset can be an internal reject or an external clear, and either one opens a fixed recovery window of `RECOV_CYC` clocks, 150 by default (3 µs at 50 MHz). Dead time stays high through that window and the peak detector is locked out for its whole length.

An event the converter never takes costs dead time only while the input is above the lower threshold. Such an event was either above the upper discriminator or vetoed by anti-coincidence. An anti-coincidence level on its own adds no dead time at all. A reference clock-enable tick is counted into a saturating live-time counter whenever dead time is low. The counter has a synchronous clear.

Top module: `deadtime_gate`

## Requirements
- R1: After a synchronous active-low reset, `dead_o` and `pd_lock_o` are 0 and `live_cnt_o` is 0.
- R2: When idle, a rising edge of `lld_i` (high now, low in the previous sampled cycle) makes `dead_o` 1 from the next clock on.
- R3: Once `conv_busy_i` is sampled high while `anti_i` is low after a trigger, `dead_o` stays 1 whatever `lld_i` does, until a reset event. It then stays 1 for exactly `RECOV_CYC` more clocks. `pd_lock_o` is 1 for exactly those clocks and then both fall together.
- R4: `reject_i` and `clear_i` each act as a reset event and start the same recovery window.
- R5: If a triggered event is never taken by the converter (no busy, or busy only while `anti_i` is high), `dead_o` falls the clock after `lld_i` is sampled low.
- R6: With `lld_i` low, `anti_i` high adds no dead time and does not stop live-time counting.
- R7: During the recovery window, rising edges of `lld_i` and further reset events are ignored and the window is not restarted. An `lld_i` level still high when the window ends does not start dead time; a fresh rising edge is needed.
- R8: `live_cnt_o` increments by one on each clock where `tick_i` is 1 and `dead_o` was 0 before that edge, and holds otherwise.
- R9: `live_cnt_o` saturates at all ones (`LIVE_W` bits, 24 by default).
- R10: `live_clr_i` clears `live_cnt_o` to 0 on the next clock and takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lld_i | input | 1 | Input is above the lower discriminator threshold |
| conv_busy_i | input | 1 | Converter has accepted the event and is busy |
| anti_i | input | 1 | Anti-coincidence inhibit status |
| reject_i | input | 1 | Single-clock internal reject reset of the converter |
| clear_i | input | 1 | Single-clock external clear reset of the converter |
| tick_i | input | 1 | Reference clock-enable tick for live time |
| live_clr_i | input | 1 | Synchronous clear of the live-time counter |
| dead_o | output | 1 | Dead-time level |
| pd_lock_o | output | 1 | Peak-detector retrigger lockout (recovery window) |
| live_cnt_o | output | LIVE_W | Live-time count |

## Verification
The assertions assume that `reject_i` and `clear_i` are single-clock pulses, and that `conv_busy_i` rises only after a trigger and falls no earlier than the reset event that ends the conversion. The stimulus follows that order: it raises busy only after `lld_i` has risen, drops busy in the same clock that it pulses a reset, and drives every input on the falling edge. Outside that order it sends only the stray events R7 says must be ignored, namely triggers and resets during the recovery window.

// File: rtl/dtg_pkg.sv
// Package: shared types for the dead-time gate.
// Assumes: nothing beyond IEEE 1800-2017.
package dtg_pkg;

    // Phase of one event as seen by the dead-time tracker.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // live, ready for a trigger
        PH_FRONT = 2'd1,   // input above lower threshold, not yet taken
        PH_BUSY  = 2'd2,   // converter has taken the event
        PH_RECOV = 2'd3    // fixed recovery window after a reset
    } gate_phase_t;

endpackage

// File: rtl/dtg_phase_fsm.sv
// Module: dtg_phase_fsm
// Tracks one event from trigger to the end of the recovery window and
// drives the dead-time level and the peak-detector lockout.
// Assumes: reject_i/clear_i are single-clock pulses; conv_busy_i only
// rises after a trigger and stays up until a reset event.
module dtg_phase_fsm
    import dtg_pkg::*;
#(
    parameter int RECOV_CYC = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lld_i,
    input  logic conv_busy_i,
    input  logic anti_i,
    input  logic reject_i,
    input  logic clear_i,
    output logic dead_o,
    output logic pd_lock_o
);

    localparam int CW = (RECOV_CYC > 1) ? $clog2(RECOV_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(RECOV_CYC - 1);

    gate_phase_t phase;
    logic [CW-1:0] rcnt;
    logic lld_q;
    logic trig;
    logic rst_evt;

    assign trig    = lld_i && !lld_q;
    assign rst_evt = reject_i || clear_i;

    // Remember the previous lower-discriminator level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lld_q <= 1'b0;
        else        lld_q <= lld_i;
    end

    // Advance the event phase and the recovery-window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            rcnt  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (trig) phase <= PH_FRONT;
                end
                PH_FRONT: begin
                    if (rst_evt) begin
                        phase <= PH_RECOV;
                        rcnt  <= '0;
                    end else if (conv_busy_i && !anti_i) begin
                        phase <= PH_BUSY;
                    end else if (!lld_i) begin
                        phase <= PH_IDLE;
                    end
                end
                PH_BUSY: begin
                    if (rst_evt) begin
                        phase <= PH_RECOV;
                        rcnt  <= '0;
                    end
                end
                PH_RECOV: begin
                    if (rcnt == LAST) begin
                        phase <= PH_IDLE;
                        rcnt  <= '0;
                    end else begin
                        rcnt <= rcnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Outputs decode the registered phase.
    assign dead_o    = (phase != PH_IDLE);
    assign pd_lock_o = (phase == PH_RECOV);

    a_r2_dead_after_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && trig) |=> dead_o);

    a_r6_idle_stays_live: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !trig) |=> !dead_o);

    a_r3_busy_holds_dead: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BUSY && !rst_evt) |=> (dead_o && !pd_lock_o));

    a_r3_lock_within_dead: assert property (@(posedge clk) disable iff (!rst_n)
        pd_lock_o |-> dead_o);

    a_r4_reset_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_FRONT || phase == PH_BUSY) && rst_evt) |=> (pd_lock_o && rcnt == '0));

    a_r7_window_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_lock_o && rcnt != LAST) |=> (pd_lock_o && rcnt == $past(rcnt) + 1'b1));

    a_r5_untaken_follows_lld: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FRONT && !lld_i && !conv_busy_i && !rst_evt) |=> !dead_o);

endmodule

// File: rtl/dtg_live_count.sv
// Module: dtg_live_count
// Counts reference ticks while dead time is low; saturates at all ones.
// Assumes: dead_i is a registered level from the phase tracker.
module dtg_live_count #(
    parameter int LIVE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dead_i,
    input  logic              tick_i,
    input  logic              clr_i,
    output logic [LIVE_W-1:0] cnt_o
);

    localparam logic [LIVE_W-1:0] FULL = {LIVE_W{1'b1}};

    logic at_full;
    assign at_full = (cnt_o == FULL);

    // Clear has priority; otherwise count live ticks until full.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_o <= '0;
        else if (clr_i)                       cnt_o <= '0;
        else if (tick_i && !dead_i && !at_full) cnt_o <= cnt_o + 1'b1;
    end

    a_r8_count_live_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && tick_i && !dead_i && !at_full) |=> (cnt_o == $past(cnt_o) + 1'b1));

    a_r8_hold_when_dead: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && dead_i) |=> $stable(cnt_o));

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && at_full) |=> (cnt_o == FULL));

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/deadtime_gate.sv
// Module: deadtime_gate (top)
// Produces the dead-time level, the peak-detector lockout and a
// saturating live-time count gated by the dead-time level.
// Assumes: all inputs are synchronous to clk.
module deadtime_gate #(
    parameter int RECOV_CYC = 150,
    parameter int LIVE_W    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lld_i,
    input  logic              conv_busy_i,
    input  logic              anti_i,
    input  logic              reject_i,
    input  logic              clear_i,
    input  logic              tick_i,
    input  logic              live_clr_i,
    output logic              dead_o,
    output logic              pd_lock_o,
    output logic [LIVE_W-1:0] live_cnt_o
);

    logic dead_w;

    // Event phase tracker.
    dtg_phase_fsm #(.RECOV_CYC(RECOV_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lld_i       (lld_i),
        .conv_busy_i (conv_busy_i),
        .anti_i      (anti_i),
        .reject_i    (reject_i),
        .clear_i     (clear_i),
        .dead_o      (dead_w),
        .pd_lock_o   (pd_lock_o)
    );

    // Live-time tick counter.
    dtg_live_count #(.LIVE_W(LIVE_W)) u_live (
        .clk    (clk),
        .rst_n  (rst_n),
        .dead_i (dead_w),
        .tick_i (tick_i),
        .clr_i  (live_clr_i),
        .cnt_o  (live_cnt_o)
    );

    assign dead_o = dead_w;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!dead_o && !pd_lock_o && live_cnt_o == '0));

endmodule

// File: tb/sim_deadtime_gate.sv
// Bench: behavioural reference model compared on every falling edge,
// plus directed checks tagged with requirements.
module sim_deadtime_gate;

    localparam int CLK_PERIOD = 10;
    localparam int RC   = 150;
    localparam int LW   = 10;
    localparam int LMAX = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lld = 1'b0, busy = 1'b0, anti = 1'b0, rej = 1'b0, clr = 1'b0;
    logic tick = 1'b0, lclr = 1'b0;
    logic dead, lock;
    logic [LW-1:0] cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state.
    int m_phase = 0;   // 0 live, 1 above threshold, 2 taken, 3 recovering
    int m_left  = 0;
    int m_live  = 0;
    bit m_prev  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    deadtime_gate #(.RECOV_CYC(RC), .LIVE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .lld_i(lld), .conv_busy_i(busy),
        .anti_i(anti), .reject_i(rej), .clear_i(clr), .tick_i(tick),
        .live_clr_i(lclr), .dead_o(dead), .pd_lock_o(lock), .live_cnt_o(cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // Reference model: updated from the inputs seen at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_live = 0; m_prev = 1'b0;
        end else begin
            if (lclr) m_live = 0;
            else if (tick && m_phase == 0 && m_live < LMAX) m_live = m_live + 1;
            if (m_phase == 0) begin
                if (lld && !m_prev) m_phase = 1;
            end else if (m_phase == 3) begin
                m_left = m_left - 1;
                if (m_left == 0) m_phase = 0;
            end else if (rej || clr) begin
                m_phase = 3; m_left = RC;
            end else if (m_phase == 1) begin
                if (busy && !anti) m_phase = 2;
                else if (!lld) m_phase = 0;
            end
            m_prev = lld;
        end
    end

    // Compare against the model on every falling edge (R3, R8 and others).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(dead == (m_phase != 0), "R3 model dead", dead, m_phase != 0);
            check(lock == (m_phase == 3), "R7 model lockout", lock, m_phase == 3);
            check(int'(cnt) == m_live, "R8 model count", cnt, m_live);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        step(3);
        rst_n = 1'b1;
        step();
        // R1 reset state
        check(!dead && !lock && cnt == 0, "R1", {dead, lock, cnt}, 0);

        // R8 live counting while idle
        tick = 1'b1;
        step(20);
        check(cnt == 20, "R8 idle ticks", cnt, 20);

        // R2 trigger, R3 accepted event ended by clear (R4)
        lld = 1'b1; step();
        check(dead == 1'b1, "R2", dead, 1);
        busy = 1'b1; step(); lld = 1'b0;
        base = cnt;
        step(10);
        check(dead && !lock, "R3 busy hold", dead, 1);
        check(cnt == base, "R8 hold while dead", cnt, base);
        busy = 1'b0; clr = 1'b1; step(); clr = 1'b0;
        for (int i = 0; i < RC; i++) begin
            if (!lock || !dead) check(1'b0, "R3 window", i, RC);
            step();
        end
        check(!lock && !dead, "R3 window end", {dead, lock}, 0);

        // R4 internal reject path
        step(2);
        lld = 1'b1; step(); busy = 1'b1; step(); lld = 1'b0; step(3);
        busy = 1'b0; rej = 1'b1; step(); rej = 1'b0;
        check(lock == 1'b1, "R4 reject opens window", lock, 1);
        step(RC - 1);
        check(lock == 1'b1, "R4 window last clock", lock, 1);
        step();
        check(!lock && !dead, "R4 window closes", {dead, lock}, 0);

        // R5 event above upper threshold: never taken
        lld = 1'b1; step(5);
        check(dead == 1'b1, "R5 above lld", dead, 1);
        lld = 1'b0; step();
        check(dead == 1'b0, "R5 untaken ends", dead, 0);

        // R5 busy while anti-inhibit high is not a conversion
        anti = 1'b1; lld = 1'b1; step(); busy = 1'b1; step(2); busy = 1'b0;
        lld = 1'b0; step();
        check(dead == 1'b0 && lock == 1'b0, "R5 inhibited ends", dead, 0);

        // R6 anti-inhibit alone: no dead time, counting continues
        base = cnt;
        step(10);
        check(dead == 1'b0, "R6 no dead", dead, 0);
        check(cnt == base + 10, "R6 still counting", cnt, base + 10);
        anti = 1'b0;

        // R7 trigger and reset during window are ignored
        lld = 1'b1; step(); busy = 1'b1; step(); lld = 1'b0; step();
        busy = 1'b0; clr = 1'b1; step(); clr = 1'b0;
        step(20); lld = 1'b1; step(); rej = 1'b1; step(); rej = 1'b0;
        step(RC - 23);
        check(lock == 1'b1, "R7 window unchanged", lock, 1);
        step();
        check(!lock && !dead, "R7 window not restarted", {dead, lock}, 0);
        step(5);
        check(dead == 1'b0, "R7 held level no retrigger", dead, 0);
        lld = 1'b0; step();
        lld = 1'b1; step();
        check(dead == 1'b1, "R7 fresh edge triggers", dead, 1);
        lld = 1'b0; step();

        // R9 saturation
        step(LMAX + 20);
        check(cnt == LMAX, "R9 saturate", cnt, LMAX);
        step(3);
        check(cnt == LMAX, "R9 stays full", cnt, LMAX);

        // R10 clear beats tick
        lclr = 1'b1; step(); lclr = 1'b0;
        check(cnt == 0, "R10 clear", cnt, 0);
        step();
        check(cnt == 1, "R10 counts after clear", cnt, 1);
        tick = 1'b0;
        step(2);
        finish_run();
    end

endmodule